// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Unit

This block is the per-processor interrupt acceptance stage. It keeps three 256-bit vector arrays: pending requests, vectors in service, and the trigger kind of each vector. Requests arrive as vector numbers from several sources, such as the local timer and the message bus, one per source per cycle. The block works out the processor priority from a software-set task priority and the highest vector in service. It raises an interrupt line to the core when a pending vector outranks that priority.

The core collects a vector with an acknowledge pulse, which moves the winning vector from pending to in service. An end-of-interrupt write retires the highest in-service vector. A 32-bit register port, addressed by byte offset, gives software access to the task priority, processor priority, end-of-interrupt, spurious-vector/enable register, the three vector arrays as 32-bit words, and a sticky illegal-address flag.

Top module: `irq_accept_unit`

## Requirements
- R1: A higher vector number has higher priority; an acknowledge that is accepted returns the highest set pending vector.
- R2: The processor priority (read at byte offset 0xA0) equals the task priority when task priority bits [7:4] are at least the class (bits [7:4]) of the highest in-service vector, with an empty in-service array counting as class 0; otherwise it is that class shifted left by 4.
- R3: `irq_out` is high only when spurious-register bit 8 is set and a vector is pending; when the processor priority is nonzero, the pending vector's class must also be strictly greater than the processor priority class.
- R4: An accepted acknowledge clears the pending bit of the returned vector and sets its in-service bit; `ack_done` pulses one cycle after `ack_req` with the result.
- R5: When the task priority is nonzero and the highest pending vector is at most the task priority, the acknowledge returns spurious-register bits [7:0] with `ack_spurious` high, and the pending and in-service arrays keep their values.
- R6: While spurious-register bit 8 is clear, `irq_out` stays low and an acknowledge reports `ack_empty` with vector 0; it also reports `ack_empty` when nothing is pending.
- R7: A write to byte offset 0xB0 clears the highest set in-service bit; reading that offset returns 0.
- R8: A request sets its pending bit and sets its trigger bit for level (`src_level`=1) or clears it for edge; if two sources name the same vector in one cycle the higher-numbered source decides the trigger bit.
- R9: Register map by byte offset (bits [3:0] ignored): task priority 0x80 (8 bits), spurious/enable 0xF0 (9 bits kept), in-service words 0x100..0x170, trigger words 0x180..0x1F0, pending words 0x200..0x270 (word k holds vectors 32k..32k+31, vector 32k in bit 0), error status 0x280; writes to 0xA0, the arrays and 0x280 are ignored.
- R10: A read or write of any other offset sets error-status bit 7, which stays set until reset; such a read returns 0.
- R11: After reset the task priority is 0, the spurious register is 0x0FF (disabled), and the pending, in-service, trigger and error-status state are all zero.
- R12: In one cycle, an end-of-interrupt acts on the in-service array as it stood before the edge and an acknowledge's in-service set wins over it; a new request for the vector being acknowledged leaves its pending bit set; acknowledge and `irq_out` use the task priority from before a same-cycle write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | NSRC | Per-source request strobe |
| src_vector | input | 8*NSRC | Per-source vector number, source s in bits [8s+7:8s] |
| src_level | input | NSRC | Per-source trigger kind, 1 = level, 0 = edge |
| ack_req | input | 1 | Core acknowledge pulse |
| ack_done | output | 1 | Acknowledge result valid (one cycle after ack_req) |
| ack_empty | output | 1 | No vector was available |
| ack_spurious | output | 1 | Returned vector is the spurious vector |
| ack_vector | output | 8 | Returned vector |
| irq_out | output | 1 | Interrupt line to the core |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the current state |

## Verification
The acknowledge and the end-of-interrupt write can land on the same edge, as can a new request and the acknowledge of that same vector, or a task-priority write and an acknowledge. The bench provokes these pairings directly and also lets the random stream overlap acknowledges, end-of-interrupt writes, task-priority writes and requests freely. A bench model applies the rules with the state from before the edge. The outcome is judged from the array words read back afterwards, together with the acknowledge result and the interrupt line on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int IRQ_NVEC  = 256;
    localparam int IRQ_WORD  = 32;
    localparam int IRQ_NWORD = IRQ_NVEC / IRQ_WORD;
    localparam int IRQ_VW    = $clog2(IRQ_NVEC);
    localparam int IRQ_WB    = $clog2(IRQ_WORD);
    localparam int IRQ_SVRW  = 9;
    localparam int IRQ_ILL_BIT = 7;

    localparam logic [IRQ_SVRW-1:0] SVR_RESET = 9'h0FF;

    localparam logic [7:0] IDX_TPR  = 8'h08;
    localparam logic [7:0] IDX_PPR  = 8'h0A;
    localparam logic [7:0] IDX_EOI  = 8'h0B;
    localparam logic [7:0] IDX_SVR  = 8'h0F;
    localparam logic [7:0] IDX_ISR0 = 8'h10;
    localparam logic [7:0] IDX_TMR0 = 8'h18;
    localparam logic [7:0] IDX_IRR0 = 8'h20;
    localparam logic [7:0] IDX_ESR  = 8'h28;
    localparam logic [7:0] IDX_NW   = 8'(IRQ_NWORD);

    typedef logic [IRQ_NVEC-1:0] vec_t;
    typedef logic [IRQ_VW-1:0]   vnum_t;

    typedef enum logic [3:0] {
        RK_NONE, RK_TPR, RK_PPR, RK_EOI, RK_SVR,
        RK_ISR, RK_TMR, RK_IRR, RK_ESR
    } reg_kind_e;

    typedef struct packed {
        logic  done;
        logic  empty;
        logic  spurious;
        vnum_t vector;
    } ack_res_t;

    function automatic reg_kind_e decode_idx(input logic [7:0] idx);
        reg_kind_e k;
        k = RK_NONE;
        if (idx == IDX_TPR)                                  k = RK_TPR;
        else if (idx == IDX_PPR)                             k = RK_PPR;
        else if (idx == IDX_EOI)                             k = RK_EOI;
        else if (idx == IDX_SVR)                             k = RK_SVR;
        else if (idx == IDX_ESR)                             k = RK_ESR;
        else if (idx >= IDX_ISR0 && idx < IDX_ISR0 + IDX_NW) k = RK_ISR;
        else if (idx >= IDX_TMR0 && idx < IDX_TMR0 + IDX_NW) k = RK_TMR;
        else if (idx >= IDX_IRR0 && idx < IDX_IRR0 + IDX_NW) k = RK_IRR;
        return k;
    endfunction

    function automatic logic [IRQ_WB-1:0] hi_in_word(input logic [IRQ_WORD-1:0] w);
        logic [IRQ_WB-1:0] r;
        r = '0;
        for (int i = 0; i < IRQ_WORD; i++) begin
            if (w[i]) r = i[IRQ_WB-1:0];
        end
        return r;
    endfunction

    function automatic vec_t one_hot(input vnum_t v);
        vec_t r;
        r = '0;
        r[v] = 1'b1;
        return r;
    endfunction

    function automatic vnum_t compute_ppr(input vnum_t tpr, input logic isr_any,
                                          input vnum_t isr_hi);
        logic [3:0] cls;
        cls = isr_any ? isr_hi[7:4] : 4'd0;
        return (tpr[7:4] >= cls) ? tpr : {cls, 4'h0};
    endfunction

endpackage

// File: rtl/irq_hi_find.sv
module irq_hi_find
    import irq_pkg::*;
#(
    parameter int N = IRQ_NVEC
) (
    input  logic [N-1:0]         bits,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int NW = N / IRQ_WORD;
    localparam int GB = (NW > 1) ? $clog2(NW) : 1;

    logic [NW-1:0]     word_any;
    logic [IRQ_WB-1:0] word_idx [NW];

    for (genvar g = 0; g < NW; g++) begin : g_word
        assign word_any[g] = |bits[g*IRQ_WORD +: IRQ_WORD];
        assign word_idx[g] = hi_in_word(bits[g*IRQ_WORD +: IRQ_WORD]);
    end

    always_comb begin
        logic [GB-1:0] sel;
        sel = '0;
        for (int g = 0; g < NW; g++) begin
            if (word_any[g]) sel = g[GB-1:0];
        end
        idx = {sel, word_idx[sel]};
    end

    assign any = |word_any;

endmodule

// File: rtl/irq_vec_state.sv
module irq_vec_state
    import irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  vec_t  set_mask,
    input  vec_t  lvl_mask,
    input  logic  ack_take,
    input  vnum_t ack_idx,
    input  logic  eoi_do,
    input  vnum_t eoi_idx,
    output vec_t  irr,
    output vec_t  isr,
    output vec_t  tmr
);
    vec_t ack_bit;
    vec_t eoi_bit;

    assign ack_bit = ack_take ? one_hot(ack_idx) : '0;
    assign eoi_bit = eoi_do   ? one_hot(eoi_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else begin
            irr <= (irr & ~ack_bit) | set_mask;
            isr <= (isr & ~eoi_bit) | ack_bit;
            tmr <= (tmr & ~set_mask) | (set_mask & lvl_mask);
        end
    end

    AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> isr[$past(ack_idx)]) else $error("ack vector not in service"); // R4

    AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((irr & $past(set_mask)) == $past(set_mask))) else $error("request lost"); // R8

    AST_TRIGGER_KIND: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((tmr & $past(set_mask)) == $past(set_mask & lvl_mask))) else $error("trigger bit wrong"); // R8

    AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (rst)
        (eoi_do && !(ack_take && ack_idx == eoi_idx)) |=> !isr[$past(eoi_idx)]) else $error("eoi did not retire"); // R7

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic                rd,
    input  logic [11:0]         addr,
    input  vnum_t               tpr,
    input  logic [IRQ_SVRW-1:0] svr,
    input  vnum_t               ppr,
    input  vec_t                irr,
    input  vec_t                isr,
    input  vec_t                tmr,
    output logic [31:0]         rdata,
    output logic                tpr_we,
    output logic                svr_we,
    output logic                eoi_we,
    output logic                esr_ill
);
    localparam int WSB = (IRQ_NWORD > 1) ? $clog2(IRQ_NWORD) : 1;

    logic [7:0]     idx;
    reg_kind_e      kind;
    logic [WSB-1:0] wsel;
    logic           unused_low;

    assign idx        = addr[11:4];
    assign unused_low = ^addr[3:0];
    assign kind       = decode_idx(idx);

    always_comb begin
        case (kind)
            RK_ISR:  wsel = WSB'(idx - IDX_ISR0);
            RK_TMR:  wsel = WSB'(idx - IDX_TMR0);
            RK_IRR:  wsel = WSB'(idx - IDX_IRR0);
            default: wsel = '0;
        endcase
    end

    always_comb begin
        rdata = '0;
        case (kind)
            RK_TPR:  rdata = {24'b0, tpr};
            RK_PPR:  rdata = {24'b0, ppr};
            RK_SVR:  rdata = {{(32-IRQ_SVRW){1'b0}}, svr};
            RK_ISR:  rdata = isr[wsel*IRQ_WORD +: IRQ_WORD];
            RK_TMR:  rdata = tmr[wsel*IRQ_WORD +: IRQ_WORD];
            RK_IRR:  rdata = irr[wsel*IRQ_WORD +: IRQ_WORD];
            RK_ESR:  rdata[IRQ_ILL_BIT] = esr_ill;
            default: rdata = '0;
        endcase
    end

    assign tpr_we = wr && (kind == RK_TPR);
    assign svr_we = wr && (kind == RK_SVR);
    assign eoi_we = wr && (kind == RK_EOI);

    always_ff @(posedge clk) begin
        if (rst)                                esr_ill <= 1'b0;
        else if ((wr || rd) && kind == RK_NONE) esr_ill <= 1'b1;
    end

    AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        ((wr || rd) && kind == RK_NONE) |=> esr_ill) else $error("illegal access not flagged"); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        esr_ill |=> esr_ill) else $error("error flag dropped"); // R10

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSRC-1:0]        src_valid,
    input  logic [NSRC*IRQ_VW-1:0] src_vector,
    input  logic [NSRC-1:0]        src_level,
    input  logic                   ack_req,
    output logic                   ack_done,
    output logic                   ack_empty,
    output logic                   ack_spurious,
    output logic [IRQ_VW-1:0]      ack_vector,
    output logic                   irq_out,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [11:0]            reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata
);
    vnum_t               tpr;
    logic [IRQ_SVRW-1:0] svr;
    vnum_t               ppr;
    vec_t                irr, isr, tmr;
    vec_t                set_mask, lvl_mask;
    logic                irr_any, isr_any;
    vnum_t               irr_hi, isr_hi;
    logic                tpr_we, svr_we, eoi_we, esr_ill;
    logic                enabled, below_tpr, ack_take;
    ack_res_t            ack_nxt, ack_q;
    logic                unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:IRQ_SVRW], esr_ill};

    // merge request sources; a later source decides the trigger bit
    always_comb begin
        set_mask = '0;
        lvl_mask = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_valid[s]) begin
                set_mask[src_vector[s*IRQ_VW +: IRQ_VW]] = 1'b1;
                lvl_mask[src_vector[s*IRQ_VW +: IRQ_VW]] = src_level[s];
            end
        end
    end

    irq_hi_find #(.N(IRQ_NVEC)) u_hi_irr (.bits(irr), .any(irr_any), .idx(irr_hi));
    irq_hi_find #(.N(IRQ_NVEC)) u_hi_isr (.bits(isr), .any(isr_any), .idx(isr_hi));

    assign ppr       = compute_ppr(tpr, isr_any, isr_hi);
    assign enabled   = svr[IRQ_SVRW-1];
    assign irq_out   = enabled && irr_any &&
                       ((ppr == '0) || (irr_hi[7:4] > ppr[7:4]));
    assign below_tpr = (tpr != '0) && (irr_hi <= tpr);
    assign ack_take  = ack_req && enabled && irr_any && !below_tpr;

    always_comb begin
        ack_nxt.done     = ack_req;
        ack_nxt.empty    = !(enabled && irr_any);
        ack_nxt.spurious = enabled && irr_any && below_tpr;
        if (ack_nxt.empty)         ack_nxt.vector = '0;
        else if (ack_nxt.spurious) ack_nxt.vector = svr[IRQ_VW-1:0];
        else                       ack_nxt.vector = irr_hi;
    end

    irq_vec_state u_state (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .lvl_mask (lvl_mask),
        .ack_take (ack_take),
        .ack_idx  (irr_hi),
        .eoi_do   (eoi_we && isr_any),
        .eoi_idx  (isr_hi),
        .irr      (irr),
        .isr      (isr),
        .tmr      (tmr)
    );

    irq_reg_port u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .addr    (reg_addr),
        .tpr     (tpr),
        .svr     (svr),
        .ppr     (ppr),
        .irr     (irr),
        .isr     (isr),
        .tmr     (tmr),
        .rdata   (reg_rdata),
        .tpr_we  (tpr_we),
        .svr_we  (svr_we),
        .eoi_we  (eoi_we),
        .esr_ill (esr_ill)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tpr   <= '0;
            svr   <= SVR_RESET;
            ack_q <= '0;
        end else begin
            if (tpr_we) tpr <= reg_wdata[IRQ_VW-1:0];
            if (svr_we) svr <= reg_wdata[IRQ_SVRW-1:0];
            ack_q <= ack_nxt;
        end
    end

    assign ack_done     = ack_q.done;
    assign ack_empty    = ack_q.empty;
    assign ack_spurious = ack_q.spurious;
    assign ack_vector   = ack_q.vector;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> svr[IRQ_SVRW-1]) else $error("irq while disabled"); // R6

    AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (ack_req && !svr[IRQ_SVRW-1]) |=> (ack_done && ack_empty)) else $error("disabled ack not empty"); // R6

    AST_ACK_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        ack_done |-> $onehot0({ack_empty, ack_spurious})) else $error("ack kinds overlap"); // R5

    AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (rst)
        ppr >= tpr) else $error("ppr below tpr"); // R2

    AST_SPUR_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack_req && below_tpr && !eoi_we) |=> $stable(isr)) else $error("spurious ack moved state"); // R5

endmodule

// File: tb/irq_accept_unit_tb.sv
`timescale 1ns/1ps
module irq_accept_unit_tb;

    localparam int NSRC = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSRC-1:0]   src_valid = '0;
    logic [NSRC*8-1:0] src_vector = '0;
    logic [NSRC-1:0]   src_level = '0;
    logic              ack_req = 1'b0;
    logic              ack_done, ack_empty, ack_spurious, irq_out;
    logic [7:0]        ack_vector;
    logic              reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0]       reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;

    int n_chk = 0;
    int n_err = 0;

    bit [255:0] m_irr, m_isr, m_tmr;
    bit [7:0]   m_tpr;
    bit [8:0]   m_svr;
    bit         m_ill;
    bit         e_done, e_empty, e_spur;
    bit [7:0]   e_vec;

    always #2 clk = ~clk;

    irq_accept_unit #(.NSRC(NSRC)) u_dut (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_vector(src_vector),
        .src_level(src_level), .ack_req(ack_req), .ack_done(ack_done),
        .ack_empty(ack_empty), .ack_spurious(ack_spurious), .ack_vector(ack_vector),
        .irq_out(irq_out), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int hi(input bit [255:0] v);
        for (int i = 255; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    function automatic bit [7:0] m_ppr();
        int c;
        c = hi(m_isr);
        if (c < 0) c = 0;
        c = c / 16;
        if (int'(m_tpr[7:4]) >= c) return m_tpr;
        return 8'(c * 16);
    endfunction

    function automatic bit m_irq();
        int h;
        bit [7:0] p;
        if (!m_svr[8]) return 1'b0;
        h = hi(m_irr);
        if (h < 0) return 1'b0;
        p = m_ppr();
        if (p != 0 && (h / 16) <= int'(p[7:4])) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit m_legal(input bit [7:0] ix);
        return ix == 8'h08 || ix == 8'h0A || ix == 8'h0B || ix == 8'h0F ||
               (ix >= 8'h10 && ix <= 8'h28);
    endfunction

    function automatic bit [31:0] m_read(input bit [11:0] a);
        int ix;
        ix = int'(a[11:4]);
        if (ix == 8) return {24'b0, m_tpr};
        if (ix == 10) return {24'b0, m_ppr()};
        if (ix == 15) return {23'b0, m_svr};
        if (ix >= 16 && ix < 24) return m_isr[(ix-16)*32 +: 32];
        if (ix >= 24 && ix < 32) return m_tmr[(ix-24)*32 +: 32];
        if (ix >= 32 && ix < 40) return m_irr[(ix-32)*32 +: 32];
        if (ix == 40) return {24'b0, m_ill, 7'b0};
        return 32'b0;
    endfunction

    task automatic tick(input string tag);
        bit [255:0] nirr, nisr, ntmr;
        bit [7:0] ntpr;
        bit [8:0] nsvr;
        bit nill, d, em, sp;
        bit [7:0] vv;
        int h, e;
        string t;
        #1;
        if (reg_rd) begin
            if (tag != "") t = tag;
            else if (!m_legal(reg_addr[11:4])) t = "R10";
            else if (reg_addr[11:4] == 8'h0A) t = "R2";
            else t = "R9";
            chk(reg_rdata === m_read(reg_addr), t, reg_rdata, m_read(reg_addr));
        end
        nirr = m_irr; nisr = m_isr; ntmr = m_tmr; ntpr = m_tpr; nsvr = m_svr; nill = m_ill;
        d = ack_req; em = 1'b0; sp = 1'b0; vv = 8'h00;
        h = hi(m_irr);
        if (ack_req) begin
            if (!m_svr[8] || h < 0) em = 1'b1;
            else if (m_tpr != 0 && h <= int'(m_tpr)) begin sp = 1'b1; vv = m_svr[7:0]; end
            else vv = 8'(h);
        end
        if (reg_wr && reg_addr[11:4] == 8'h0B) begin
            e = hi(m_isr);
            if (e >= 0) nisr[e] = 1'b0;
        end
        if (ack_req && !em && !sp) begin nirr[h] = 1'b0; nisr[h] = 1'b1; end
        for (int s = 0; s < NSRC; s++) begin
            if (src_valid[s]) begin
                nirr[src_vector[s*8 +: 8]] = 1'b1;
                ntmr[src_vector[s*8 +: 8]] = src_level[s];
            end
        end
        if (reg_wr && reg_addr[11:4] == 8'h08) ntpr = reg_wdata[7:0];
        if (reg_wr && reg_addr[11:4] == 8'h0F) nsvr = reg_wdata[8:0];
        if ((reg_wr || reg_rd) && !m_legal(reg_addr[11:4])) nill = 1'b1;
        @(posedge clk);
        m_irr = nirr; m_isr = nisr; m_tmr = ntmr; m_tpr = ntpr; m_svr = nsvr; m_ill = nill;
        e_done = d; e_empty = em; e_spur = sp; e_vec = vv;
        @(negedge clk);
        chk(irq_out === m_irq(), "R3", {31'b0, irq_out}, {31'b0, m_irq()});
        chk(ack_done === e_done, "R4", {31'b0, ack_done}, {31'b0, e_done});
        if (e_done) begin
            t = e_empty ? "R6" : (e_spur ? "R5" : "R1");
            chk(ack_vector === e_vec, t, {24'b0, ack_vector}, {24'b0, e_vec});
            chk(ack_empty === e_empty, "R6", {31'b0, ack_empty}, {31'b0, e_empty});
            chk(ack_spurious === e_spur, "R5", {31'b0, ack_spurious}, {31'b0, e_spur});
        end
        src_valid = '0; ack_req = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        reg_rd = 1'b1; reg_addr = a; tick(tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    endtask

    task automatic src(input int s, input logic [7:0] v, input logic lvl);
        src_valid[s] = 1'b1; src_vector[s*8 +: 8] = v; src_level[s] = lvl;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h1F2E3D4C);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 0; m_svr = 9'h0FF; m_ill = 0;
        e_done = 0;
        // R11: reset state
        rd(12'h080, "R11"); rd(12'h0F0, "R11"); rd(12'h280, "R11");
        for (int k = 0; k < 8; k++) rd(12'h200 + 12'(k*16), "R11");
        // R6: disabled unit holds requests but signals nothing
        src(0, 8'h40, 1'b0); tick("");
        ack_req = 1'b1; tick("");
        rd(12'h220, "R8");
        wr(12'h0F0, 32'h1FF); tick("");
        // R8: two sources at once, level and edge
        src(0, 8'h45, 1'b1); src(1, 8'h30, 1'b0); tick("");
        rd(12'h1A0, "R8"); rd(12'h190, "R8");
        ack_req = 1'b1; tick("");            // R1 returns 0x45
        rd(12'h120, "R4"); rd(12'h220, "R4");
        rd(12'h0A0, "R2");
        wr(12'h080, 32'h50); tick("");
        rd(12'h0A0, "R2");
        ack_req = 1'b1; tick("");            // R5 spurious
        rd(12'h220, "R5"); rd(12'h120, "R5");
        wr(12'h080, 32'h0); ack_req = 1'b1; tick("");  // R12 old tpr used
        wr(12'h0B0, 32'h0); tick("");        // R7
        rd(12'h120, "R7"); rd(12'h0B0, "R7");
        ack_req = 1'b1; tick("");
        wr(12'h0B0, 32'h0); ack_req = 1'b1; tick("");  // R12 eoi and ack together
        rd(12'h110, "R12"); rd(12'h120, "R12");
        src(0, 8'h20, 1'b0); tick("");
        src(1, 8'h20, 1'b1); ack_req = 1'b1; tick("");  // R12 re-request while acked
        rd(12'h210, "R12"); rd(12'h190, "R12");
        wr(12'h0A0, 32'hFF); tick("");       // R9 ignored write
        rd(12'h0A0, "R9");
        rd(12'h300, "R10"); rd(12'h280, "R10");
        wr(12'h030, 32'h1); tick("");
        rd(12'h280, "R10");
        // random mix
        for (int n = 0; n < 4000; n++) begin
            for (int s = 0; s < NSRC; s++) begin
                if ($urandom_range(0, 3) == 0)
                    src(s, 8'($urandom_range(1, 15) * 16 + $urandom_range(0, 3)),
                        1'($urandom_range(0, 1)));
            end
            ack_req = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 19))
                0, 1:  wr(12'h080, 32'($urandom_range(0, 15) * 16 + $urandom_range(0, 15)));
                2, 3:  wr(12'h0B0, 32'h0);
                4:     wr(12'h0F0, ($urandom_range(0, 9) == 0) ? 32'h0EE : 32'h1EE);
                5, 6:  begin reg_rd = 1'b1; reg_addr = 12'h0A0; end
                7, 8:  begin reg_rd = 1'b1; reg_addr = 12'h100 + 12'($urandom_range(0, 39) * 16); end
                9:     begin reg_rd = 1'b1; reg_addr = 12'($urandom_range(0, 4095)); end
                default: ;
            endcase
            tick("");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule